// File: doc/BRIEF.md
# Register-Space Arithmetic/Logic Unit

An 8-bit combinational arithmetic/logic unit for operations whose destination is a register-space location. Each operation reads a destination operand and, except for increment and decrement, a second operand taken either from a register value or from an immediate value. The unit returns the computed byte, a write-enable that tells the surrounding register file whether to store that byte back into the destination, and the new sign, zero and carry flags.

The carry flag follows per-operation rules. Additive and subtractive operations replace it, and subtractive operations report a borrow as carry = 1. Bitwise operations pass the incoming carry through unchanged. Compare and test-mask produce flags only and never request a write. The operation code is a 4-bit field internal to this block.

Top module: `regop_alu`

## Requirements
- R1: `opSel` encodes the operations as 0 ADD, 1 ADC, 2 SUB, 3 SUBC, 4 CP, 5 INC, 6 DEC, 7 AND, 8 TM, 9 OR, 10 XOR.
- R2: ADD gives `result` = low 8 bits of dst + operand, and ADC gives dst + operand + `carryIn`. In both, `carryFlag` is the carry out of bit 7.
- R3: SUB and CP give dst − operand, and SUBC gives dst − operand − `carryIn`, all modulo 256. In all three, `carryFlag` is 1 exactly when a borrow occurs (the subtrahend total exceeds dst).
- R4: INC gives dst + 1 with `carryFlag` = 1 only for dst = 0xFF. DEC gives dst − 1 with `carryFlag` = 1 only for dst = 0x00. `srcVal`, `immVal` and `immSel` have no effect on any output.
- R5: AND, TM, OR and XOR give the bitwise and/and/or/xor of dst and operand, and `carryFlag` equals `carryIn`.
- R6: `writeEn` is 1 for ADD, ADC, SUB, SUBC, INC, DEC, AND, OR and XOR, and 0 for CP and TM.
- R7: For every code, `signFlag` equals `result` bit 7 and `zeroFlag` is 1 exactly when `result` is 0x00.
- R8: For all operations other than INC and DEC, the operand is `immVal` when `immSel` = 1 and `srcVal` when `immSel` = 0.
- R9: Codes 11 to 15 give `writeEn` = 0 and `carryFlag` = `carryIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 4 | Operation code |
| dstVal | input | 8 | Destination register contents |
| srcVal | input | 8 | Source register contents |
| immVal | input | 8 | Immediate operand |
| immSel | input | 1 | 1 selects the immediate operand |
| carryIn | input | 1 | Current carry flag |
| result | output | 8 | Computed value |
| writeEn | output | 1 | Store result into the destination |
| signFlag | output | 1 | New sign flag |
| zeroFlag | output | 1 | New zero flag |
| carryFlag | output | 1 | New carry flag |

## Verification
Carry generation and zero detection can fire on the same operation. Examples are ADD of 0xFF and 0x01, which gives 0x00 with carry 1, and SUBC from 0x00 with carry-in 1, which gives 0xFF with a borrow. Sweeping every destination byte against a set of edge operands, with both carry-in values and both source selections, hits these cases for every code. Each output field is then compared with a reference computed with integer arithmetic. The register and immediate inputs always carry different values, so taking the wrong source shows up as a mismatch.

// File: rtl/regop_alu_pkg.sv
package regop_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SUBC = 4'd3,
    OP_CP  = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_AND  = 4'd7,
    OP_TM  = 4'd8, OP_OR  = 4'd9, OP_XOR = 4'd10
  } aluOp_e;

  typedef enum logic [2:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR
  } aluKind_e;

  // strobes from control to datapath
  typedef struct packed {
    aluKind_e kind;
    logic     selImm;
    logic     forceOne;
    logic     useCarry;
    logic     updCarry;
    logic     wrEn;
  } aluStrobe_t;
endpackage

// File: rtl/regop_alu_ctrl.sv
module regop_alu_ctrl
  import regop_alu_pkg::*;
(
  input  logic [3:0]  opSel,
  input  logic        immSel,
  output aluStrobe_t  strobe
);
  always_comb begin
    strobe.kind     = K_AND;
    strobe.selImm   = immSel;
    strobe.forceOne = 1'b0;
    strobe.useCarry = 1'b0;
    strobe.updCarry = 1'b0;
    strobe.wrEn     = 1'b0;
    case (opSel)
      OP_ADD:  begin strobe.kind = K_ADD; strobe.updCarry = 1'b1; strobe.wrEn = 1'b1; end
      OP_ADC:  begin strobe.kind = K_ADD; strobe.updCarry = 1'b1; strobe.wrEn = 1'b1;
                     strobe.useCarry = 1'b1; end
      OP_SUB:  begin strobe.kind = K_SUB; strobe.updCarry = 1'b1; strobe.wrEn = 1'b1; end
      OP_SUBC: begin strobe.kind = K_SUB; strobe.updCarry = 1'b1; strobe.wrEn = 1'b1;
                     strobe.useCarry = 1'b1; end
      OP_CP:   begin strobe.kind = K_SUB; strobe.updCarry = 1'b1; end
      OP_INC:  begin strobe.kind = K_ADD; strobe.updCarry = 1'b1; strobe.wrEn = 1'b1;
                     strobe.forceOne = 1'b1; strobe.selImm = 1'b0; end
      OP_DEC:  begin strobe.kind = K_SUB; strobe.updCarry = 1'b1; strobe.wrEn = 1'b1;
                     strobe.forceOne = 1'b1; strobe.selImm = 1'b0; end
      OP_AND:  begin strobe.kind = K_AND; strobe.wrEn = 1'b1; end
      OP_TM:   begin strobe.kind = K_AND; end
      OP_OR:   begin strobe.kind = K_OR;  strobe.wrEn = 1'b1; end
      OP_XOR:  begin strobe.kind = K_XOR; strobe.wrEn = 1'b1; end
      default: begin strobe.kind = K_AND; end
    endcase
  end
endmodule

// File: rtl/regop_alu_dpath.sv
module regop_alu_dpath
  import regop_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  aluStrobe_t        strobe,
  input  logic [WIDTH-1:0]  dstVal,
  input  logic [WIDTH-1:0]  srcVal,
  input  logic [WIDTH-1:0]  immVal,
  input  logic              carryIn,
  output logic [WIDTH-1:0]  result,
  output logic              signFlag,
  output logic              zeroFlag,
  output logic              carryFlag
);
  localparam int XW = WIDTH + 1;

  logic [WIDTH-1:0] opB;
  logic [XW-1:0]    cinExt;
  logic [XW-1:0]    wide;

  always_comb begin
    if (strobe.forceOne)    opB = WIDTH'(1);
    else if (strobe.selImm) opB = immVal;
    else                    opB = srcVal;
    cinExt = {{WIDTH{1'b0}}, strobe.useCarry & carryIn};
    case (strobe.kind)
      K_ADD:   wide = {1'b0, dstVal} + {1'b0, opB} + cinExt;
      K_SUB:   wide = {1'b0, dstVal} - {1'b0, opB} - cinExt;
      K_OR:    wide = {1'b0, dstVal | opB};
      K_XOR:   wide = {1'b0, dstVal ^ opB};
      default: wide = {1'b0, dstVal & opB};
    endcase
  end

  assign result    = wide[WIDTH-1:0];
  assign signFlag  = wide[WIDTH-1];
  assign zeroFlag  = (wide[WIDTH-1:0] == '0);
  assign carryFlag = strobe.updCarry ? wide[WIDTH] : carryIn;
endmodule

// File: rtl/regop_alu.sv
module regop_alu
  import regop_alu_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic [7:0] dstVal,
  input  logic [7:0] srcVal,
  input  logic [7:0] immVal,
  input  logic       immSel,
  input  logic       carryIn,
  output logic [7:0] result,
  output logic       writeEn,
  output logic       signFlag,
  output logic       zeroFlag,
  output logic       carryFlag
);
  aluStrobe_t strobe;

  regop_alu_ctrl u_ctrl (
    .opSel  (opSel),
    .immSel (immSel),
    .strobe (strobe)
  );

  regop_alu_dpath #(.WIDTH(8)) u_dpath (
    .strobe    (strobe),
    .dstVal    (dstVal),
    .srcVal    (srcVal),
    .immVal    (immVal),
    .carryIn   (carryIn),
    .result    (result),
    .signFlag  (signFlag),
    .zeroFlag  (zeroFlag),
    .carryFlag (carryFlag)
  );

  assign writeEn = strobe.wrEn;
endmodule

// File: rtl/regop_alu_chk.sv
module regop_alu_chk (
  input logic [3:0] opSel,
  input logic [7:0] dstVal,
  input logic [7:0] srcVal,
  input logic [7:0] immVal,
  input logic       immSel,
  input logic       carryIn,
  input logic [7:0] result,
  input logic       writeEn,
  input logic       signFlag,
  input logic       zeroFlag,
  input logic       carryFlag
);
  logic [7:0] operand;
  logic [8:0] addRef;
  assign operand = immSel ? immVal : srcVal;
  assign addRef  = {1'b0, dstVal} + {1'b0, operand};

  always_comb begin
    // R6
    flag_only_chk: assert (!((opSel == 4'd4 || opSel == 4'd8) && writeEn))
      else $error("compare/test wrote back");
    // R5
    logic_carry_chk: assert (!(opSel >= 4'd7 && opSel <= 4'd10) || carryFlag == carryIn)
      else $error("logical op changed carry");
    // R9
    unused_code_chk: assert (opSel <= 4'd10 || (!writeEn && carryFlag == carryIn))
      else $error("unused code had effect");
    // R7
    sign_zero_chk: assert (signFlag == result[7] && zeroFlag == (result == 8'h00))
      else $error("sign/zero mismatch");
    // R4
    inc_only_dst_chk: assert (opSel != 4'd5 || (result == dstVal + 8'd1 && carryFlag == (dstVal == 8'hFF)))
      else $error("INC used a source");
    // R2
    add_sum_chk: assert (opSel != 4'd0 || {carryFlag, result} == addRef)
      else $error("ADD sum mismatch");
  end
endmodule

bind regop_alu regop_alu_chk u_chk (.*);

// File: tb/sim_regop_alu.sv
module sim_regop_alu;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] opSel = '0;
  logic [7:0] dstVal = '0, srcVal = '0, immVal = '0;
  logic immSel = 1'b0, carryIn = 1'b0;
  logic [7:0] result;
  logic writeEn, signFlag, zeroFlag, carryFlag;

  int nRun = 0, nFail = 0;
  bit done = 0;

  regop_alu u0 (.*);

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s op=%0d dst=%h src=%h imm=%h isel=%0b cin=%0b act=%h exp=%h",
               req, opSel, dstVal, srcVal, immVal, immSel, carryIn, act, exp);
    end
  endtask

  function automatic string reqOf(int op);
    case (op)
      0, 1:        return "R2";
      2, 3, 4:     return "R3";
      5, 6:        return "R4";
      7, 8, 9, 10: return "R5";
      default:     return "R9";
    endcase
  endfunction

  // expected {result, writeEn, sign, zero, carry}
  function automatic logic [11:0] model(int op, int d, int s, int im, int isel, int ci);
    int b, r, c, w;
    b = isel ? im : s;
    c = ci; w = 1;
    case (op)
      0: begin r = d + b;      c = r > 255 ? 1 : 0; end
      1: begin r = d + b + ci; c = r > 255 ? 1 : 0; end
      2: begin r = d - b;      c = r < 0 ? 1 : 0; end
      3: begin r = d - b - ci; c = r < 0 ? 1 : 0; end
      4: begin r = d - b;      c = r < 0 ? 1 : 0; w = 0; end
      5: begin r = d + 1;      c = r > 255 ? 1 : 0; end
      6: begin r = d - 1;      c = r < 0 ? 1 : 0; end
      7: r = d & b;
      8: begin r = d & b; w = 0; end
      9: r = d | b;
      10: r = d ^ b;
      default: begin r = d & b; w = 0; end
    endcase
    r = r & 255;
    return {r[7:0], w[0], r[7], (r == 0) ? 1'b1 : 1'b0, c[0]};
  endfunction

  initial begin
    automatic int srcSet[8] = '{0, 1, 2, 127, 128, 129, 254, 255};
    #2;
    // all-zero inputs: ADD of zeros gives zero flag, write, no carry (R2, R7)
    #1 chk("R7", {result, writeEn, signFlag, zeroFlag, carryFlag}, {8'h00, 4'b1010});
    // same-cycle carry and zero: FF + 01 (R2)
    opSel = 4'd0; dstVal = 8'hFF; srcVal = 8'h01;
    #1 chk("R2", {result, writeEn, signFlag, zeroFlag, carryFlag}, {8'h00, 4'b1011});
    // SUBC borrow from zero with carry in (R3)
    opSel = 4'd3; dstVal = 8'h00; srcVal = 8'h00; carryIn = 1'b1;
    #1 chk("R3", {result, writeEn, signFlag, zeroFlag, carryFlag}, {8'hFF, 4'b1101});
    // sweep, R1 code map covered by the model's op indices
    for (int op = 0; op < 16; op++)
      for (int d = 0; d < 256; d++)
        for (int si = 0; si < 8; si++)
          for (int ci = 0; ci < 2; ci++)
            for (int is = 0; is < 2; is++) begin
              opSel = op[3:0]; dstVal = d[7:0];
              srcVal = srcSet[si][7:0]; immVal = srcVal ^ 8'h5A;
              immSel = is[0]; carryIn = ci[0];
              #1;
              // R8 operand selection is part of every comparison
              chk(op == 0 ? "R1" : reqOf(op), {result, writeEn, signFlag, zeroFlag, carryFlag},
                  model(op, d, srcSet[si], srcSet[si] ^ 8'h5A, is, ci));
              if (op == 8 || op == 4) chk("R6", {11'd0, writeEn}, 12'd0);
              if (op == 7 && is == 1) chk("R8", {4'd0, result}, {4'd0, dstVal & immVal});
            end
    done = 1;
  end

  initial begin
    for (int cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
    end
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule